// File: doc/BRIEF.md
# FIR Multiply-Accumulate Engine

This block is a fixed-point FIR filter datapath that computes one output per input sample with a single shared multiplier. Each accepted sample is written into a circular history buffer. A sequential loop then pairs each stored sample with one tap weight. The history buffer and the weight bank are separate register arrays, so every loop cycle reads one sample and one weight together. The accumulator is cleared when a sample is accepted. Every loop step adds one doubled product to it, and the last step also adds the rounding constant. When the loop ends, the history pointer moves back one slot, so the next sample overwrites the oldest one.

The sample and weight words are two's-complement fractions. The accumulator has a guard byte above two word-wide halves. The output is the upper half after rounding, clipped to the word range when the guard bits hold significant data. Weights are loaded through a simple write port that the engine honours only while it is idle. The upstream side uses a valid/ready handshake. The downstream side receives a one-cycle valid pulse with the data.

Top module: `fir_mac_engine`

## Requirements
- R1: After reset, in_ready_o is 1, out_valid_o is 0 and out_data_o is 0. The history buffer and the weight bank hold zeros, so the first output is 0 if no weight has been loaded.
- R2: Each output is the sum over k = 0..TAPS-1 of w[k]·x[n-k]. Here x[n] is the sample just accepted, x[n-k] is the sample accepted k inputs earlier, and slots never written count as 0.
- R3: Words are signed Q1.(DW-1) fractions. Each product is doubled, 2^(DW-1) is added once to the sum, and the output is bits [2·DW-1:DW] of the result. Example: 1 LSB × 0x400000 gives 1, and −1 LSB × 0x400000 gives 0.
- R4: If the rounded sum lies outside the signed DW-bit range of the output field, out_data_o saturates: to 0x7FFFFF when positive and 0x800000 when negative. This includes the case 0x800000 × 0x800000.
- R5: The history holds exactly TAPS samples. A sample accepted TAPS or more inputs ago no longer contributes, and this stays true across any number of buffer wraps.
- R6: A sample is accepted when in_valid_i and in_ready_o are both 1 at a rising edge. in_ready_o is then 0 until out_valid_o has pulsed. out_valid_o is high for exactly one cycle, which begins TAPS rising edges after the accepting edge, and in_ready_o returns to 1 in the following cycle.
- R7: in_valid_i asserted while in_ready_o is 0 has no effect on the history buffer or on any later output.
- R8: While the engine is idle, coef_we_i writes coef_data_i to weight w[coef_addr_i]. Weight 0 pairs with the newest sample. A write to an address of TAPS or above is ignored.
- R9: A weight write issued while in_ready_o is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input sample valid |
| in_data_i | input | DW | Input sample, signed fraction |
| in_ready_o | output | 1 | Engine idle, sample may be accepted |
| out_valid_o | output | 1 | One-cycle output strobe |
| out_data_o | output | DW | Rounded, saturated output sample |
| coef_we_i | input | 1 | Weight write enable |
| coef_addr_i | input | AW | Weight index |
| coef_data_i | input | DW | Weight value, signed fraction |

## Verification
The bench uses an impulse to show that weight 0 pairs with the newest sample. A reversed pairing would show up as a mirrored response. It feeds more than two buffer lengths of pseudo-random data, so that a pointer stepping the wrong way or wrapping at the wrong count corrupts later outputs. Two weight values sit exactly on the rounding tie, and a truncating or symmetric rounder gives a different result for them. Two inputs, the doubled (−1)·(−1) product and all-full-scale inputs, overflow the output range, and an unsaturated design would wrap their sign. Samples and weight writes are also issued while the loop runs, and a design that fails to block them would change the outputs that follow.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_EMIT
  } fir_state_e;
endpackage

// File: rtl/fir_sample_ring.sv
module fir_sample_ring #(
  parameter int unsigned TAPS = 20,
  parameter int unsigned DW   = 24,
  parameter int unsigned AW   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_off_i,
  input  logic          step_i,
  output logic [DW-1:0] rd_data_o
);
  localparam logic [AW:0] TAPS_W = (AW+1)'(TAPS);

  logic [TAPS-1:0][DW-1:0] mem_q;
  logic [AW-1:0]           ptr_q;
  logic [TAPS-1:0]         slot_hit;
  logic [AW:0]             addr_sum;
  logic [AW-1:0]           rd_addr;

  for (genvar s = 0; s < TAPS; s++) begin : g_hit
    assign slot_hit[s] = wr_en_i && (ptr_q == AW'(s));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      for (int s = 0; s < TAPS; s++) begin
        if (slot_hit[s]) mem_q[s] <= wr_data_i;
      end
    end
  end

  // newest at ptr, older entries at higher addresses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (step_i) ptr_q <= (ptr_q == '0) ? AW'(TAPS-1) : ptr_q - 1'b1;
  end

  always_comb begin
    addr_sum = {1'b0, ptr_q} + {1'b0, rd_off_i};
    if (addr_sum >= TAPS_W) addr_sum = addr_sum - TAPS_W;
    rd_addr = addr_sum[AW-1:0];
  end

  assign rd_data_o = mem_q[rd_addr];

  // R5
  ptr_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q < AW'(TAPS));

  // R7
  hist_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mem_q));
endmodule

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int unsigned TAPS = 20,
  parameter int unsigned DW   = 24,
  parameter int unsigned AW   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lock_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [TAPS-1:0][DW-1:0] mem_q;
  logic [TAPS-1:0]         slot_we;

  for (genvar s = 0; s < TAPS; s++) begin : g_we
    assign slot_we[s] = wr_en_i && !lock_i && (wr_addr_i == AW'(s));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      for (int s = 0; s < TAPS; s++) begin
        if (slot_we[s]) mem_q[s] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  // R9
  coef_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(mem_q));
endmodule

// File: rtl/fir_mac_unit.sv
module fir_mac_unit #(
  parameter int unsigned DW    = 24,
  parameter int unsigned EXT_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          mac_en_i,
  input  logic          round_i,
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] coef_i,
  output logic [DW-1:0] result_o
);
  localparam int unsigned PW    = 2 * DW;
  localparam int unsigned ACC_W = EXT_W + PW;
  localparam logic signed [ACC_W-1:0] RND =
    {{(ACC_W-DW){1'b0}}, 1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] SAT_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SAT_MIN = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW-1:0]    smp_s, coef_s;
  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] term;
  logic signed [ACC_W-1:0] acc_q;
  logic [EXT_W:0]          guard;
  logic                    ovf;

  assign smp_s  = smp_i;
  assign coef_s = coef_i;
  assign prod   = smp_s * coef_s;
  // drop duplicate sign bit of the fractional product
  assign term   = {{(ACC_W-PW){prod[PW-1]}}, prod} <<< 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (clear_i)  acc_q <= '0;
    else if (mac_en_i) acc_q <= acc_q + term + (round_i ? RND : '0);
  end

  assign guard = acc_q[ACC_W-1:PW-1];
  assign ovf   = !((&guard) || !(|guard));

  always_comb begin
    if (!ovf)                 result_o = acc_q[PW-1:DW];
    else if (acc_q[ACC_W-1])  result_o = SAT_MIN;
    else                      result_o = SAT_MAX;
  end
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine #(
  parameter int unsigned TAPS  = 20,
  parameter int unsigned DW    = 24,
  parameter int unsigned EXT_W = 8,
  parameter int unsigned AW    = $clog2(TAPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  output logic          in_ready_o,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o,
  input  logic          coef_we_i,
  input  logic [AW-1:0] coef_addr_i,
  input  logic [DW-1:0] coef_data_i
);
  import fir_mac_pkg::*;

  localparam logic [AW-1:0] LAST_IDX = AW'(TAPS-1);

  fir_state_e    state_q;
  logic [AW-1:0] idx_q;
  logic          accept;
  logic          last_step;
  logic [DW-1:0] smp_rd, coef_rd;

  assign accept    = (state_q == ST_IDLE) && in_valid_i;
  assign last_step = (state_q == ST_RUN) && (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (in_valid_i) begin
          state_q <= ST_RUN;
          idx_q   <= '0;
        end
        ST_RUN: begin
          if (last_step) begin
            state_q <= ST_EMIT;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_EMIT: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  fir_sample_ring #(.TAPS(TAPS), .DW(DW), .AW(AW)) u_ring (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (accept),
    .wr_data_i(in_data_i),
    .rd_off_i (idx_q),
    .step_i   (state_q == ST_EMIT),
    .rd_data_o(smp_rd)
  );

  fir_coef_bank #(.TAPS(TAPS), .DW(DW), .AW(AW)) u_coef (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lock_i   (state_q != ST_IDLE),
    .wr_en_i  (coef_we_i),
    .wr_addr_i(coef_addr_i),
    .wr_data_i(coef_data_i),
    .rd_addr_i(idx_q),
    .rd_data_o(coef_rd)
  );

  fir_mac_unit #(.DW(DW), .EXT_W(EXT_W)) u_mac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .mac_en_i(state_q == ST_RUN),
    .round_i (last_step),
    .smp_i   (smp_rd),
    .coef_i  (coef_rd),
    .result_o(out_data_o)
  );

  assign in_ready_o  = (state_q == ST_IDLE);
  assign out_valid_o = (state_q == ST_EMIT);

  // R6
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);

  // R6
  out_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> (!out_valid_o && in_ready_o));

  // R6
  idx_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX);
endmodule

// File: tb/fir_mac_engine_bench.sv
module fir_mac_engine_bench;
  localparam int TAPS = 20;
  localparam int DW   = 24;
  localparam int AW   = $clog2(TAPS);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0;
  logic [DW-1:0] in_data_i = '0;
  logic          in_ready_o;
  logic          out_valid_o;
  logic [DW-1:0] out_data_o;
  logic          coef_we_i = 1'b0;
  logic [AW-1:0] coef_addr_i = '0;
  logic [DW-1:0] coef_data_i = '0;

  int n_checks = 0;
  int n_fail   = 0;
  longint coef_m [TAPS];
  longint hist_m [TAPS];
  logic [31:0] seed = 32'h1234_abcd;
  logic [DW-1:0] last_out;

  always #10 clk_i = ~clk_i;

  fir_mac_engine #(.TAPS(TAPS), .DW(DW)) u_fir_mac_engine (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .coef_we_i(coef_we_i), .coef_addr_i(coef_addr_i), .coef_data_i(coef_data_i)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic longint sx(input logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic logic [DW-1:0] model_out();
    longint s = 0;
    longint hi;
    for (int k = 0; k < TAPS; k++) s += coef_m[k] * hist_m[k];
    s = s * 2 + 64'sd8388608;
    hi = s >>> 24;
    if (hi > 64'sd8388607)  hi = 64'sd8388607;
    if (hi < -64'sd8388608) hi = -64'sd8388608;
    return hi[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] next_rand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed[31:8];
  endfunction

  task automatic write_coef(input int addr, input logic [DW-1:0] val);
    @(negedge clk_i);
    coef_we_i = 1'b1; coef_addr_i = AW'(addr); coef_data_i = val;
    @(negedge clk_i);
    coef_we_i = 1'b0;
    if (addr < TAPS) coef_m[addr] = sx(val);
  endtask

  // push one sample, check handshake timing and the output; poke drives junk while busy
  task automatic push(input logic [DW-1:0] val, input string req, input bit poke);
    logic [DW-1:0] exp;
    int cnt = 0;
    @(negedge clk_i);
    while (!in_ready_o) @(negedge clk_i);
    in_valid_i = 1'b1; in_data_i = val;
    for (int k = TAPS-1; k > 0; k--) hist_m[k] = hist_m[k-1];
    hist_m[0] = sx(val);
    exp = model_out();
    @(negedge clk_i);
    in_valid_i = 1'b0;
    cnt = 1;
    while (!out_valid_o && cnt < 3*TAPS) begin
      if (poke && cnt == 3) begin
        check(in_ready_o == 1'b0, "R6", in_ready_o, 0);
        in_valid_i = 1'b1; in_data_i = 24'h5a5a5a;
        coef_we_i = 1'b1; coef_addr_i = '0; coef_data_i = 24'h7fffff;
      end else begin
        in_valid_i = 1'b0; coef_we_i = 1'b0;
      end
      @(negedge clk_i);
      cnt++;
    end
    in_valid_i = 1'b0; coef_we_i = 1'b0;
    // accept edge, then TAPS edges to the strobe cycle
    check(cnt == TAPS + 1, "R6", cnt, TAPS + 1);
    check(out_data_o == exp, req, out_data_o, exp);
    last_out = out_data_o;
    @(negedge clk_i);
    check(!out_valid_o && in_ready_o, "R6", {out_valid_o, in_ready_o}, 2'b01);
  endtask

  task automatic t_reset();
    check(in_ready_o == 1'b1, "R1", in_ready_o, 1);
    check(out_valid_o == 1'b0, "R1", out_valid_o, 0);
    check(out_data_o == '0, "R1", out_data_o, 0);
    push(24'h123456, "R1", 1'b0);
    check(last_out == '0, "R1", last_out, 0);
  endtask

  task automatic t_impulse();
    for (int k = 0; k < TAPS; k++)
      write_coef(k, (k % 2 == 0) ? DW'((k+1) * 24'h010203) : DW'(-((k+1) * 24'h010203)));
    for (int k = 0; k < TAPS; k++) push('0, "R2", 1'b0);
    push(24'h400000, "R2", 1'b0);
    check(sx(last_out) == (coef_m[0] + 1) / 2, "R2", last_out, (coef_m[0] + 1) / 2);
    for (int k = 1; k < TAPS + 2; k++) push('0, "R2", 1'b0);
    check(last_out == '0, "R5", last_out, 0);
  endtask

  task automatic t_wrap();
    for (int k = 0; k < TAPS; k++) write_coef(k, next_rand() >>> 3);
    for (int j = 0; j < 2*TAPS + 3; j++) push(next_rand(), "R5", 1'b0);
  endtask

  task automatic t_round();
    for (int k = 0; k < TAPS; k++) write_coef(k, '0);
    write_coef(0, 24'h000001);
    push(24'h400000, "R3", 1'b0);
    check(last_out == 24'h000001, "R3", last_out, 1);
    write_coef(0, 24'hffffff);
    push(24'h400000, "R3", 1'b0);
    check(last_out == 24'h000000, "R3", last_out, 0);
    write_coef(0, 24'h400000);
    push(24'h400000, "R3", 1'b0);
    check(last_out == 24'h200000, "R3", last_out, 24'h200000);
    write_coef(0, 24'h800000);
    push(24'h800000, "R4", 1'b0);
    check(last_out == 24'h7fffff, "R4", last_out, 24'h7fffff);
  endtask

  task automatic t_sat();
    for (int k = 0; k < TAPS; k++) write_coef(k, 24'h7fffff);
    for (int j = 0; j < TAPS; j++) push(24'h7fffff, "R4", 1'b0);
    check(last_out == 24'h7fffff, "R4", last_out, 24'h7fffff);
    for (int j = 0; j < TAPS; j++) push(24'h800000, "R4", 1'b0);
    check(last_out == 24'h800000, "R4", last_out, 24'h800000);
  endtask

  task automatic t_busy();
    for (int k = 0; k < TAPS; k++) write_coef(k, DW'(24'h030000 + k * 24'h001111));
    push(24'h222222, "R7", 1'b1);
    push(24'h333333, "R7", 1'b1);
    push(24'h100000, "R9", 1'b0);
    for (int j = 0; j < TAPS; j++) push(next_rand(), "R7", 1'b0);
  endtask

  task automatic t_addr();
    write_coef(TAPS + 3, 24'h7fffff);
    write_coef(1, 24'h200000);
    for (int j = 0; j < 4; j++) push(next_rand(), "R8", 1'b0);
  endtask

  initial begin
    for (int k = 0; k < TAPS; k++) begin coef_m[k] = 0; hist_m[k] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_impulse();
    t_wrap();
    t_round();
    t_sat();
    t_busy();
    t_addr();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule